// File: doc/BRIEF.md
# Compare-Set PWM Channel

This block drives one pulse-width-modulated output from a free-running timebase counter that advances only on a clock-enable strobe. A compare value sets how many timebase ticks the output spends low in each period. When the counter reaches the compare value, the output is driven high. When the counter wraps from all-ones back to zero, the output is driven low. The fraction of each period spent high is therefore (2^CNT_W − compare) / 2^CNT_W.

The compare value is loaded through a byte-wide write port, one byte per write. Writing the least significant byte turns the comparator off. Writing the most significant byte turns it back on. Software writes the low byte first, so a half-updated value never produces a match. With the comparator off, no match occurs and the output falls at the next wrap, which gives a 0% duty cycle.

Each match sets a sticky flag. When interrupts are enabled, the flag raises an interrupt, so that software can time its compare updates to the period.

Top module: `pwm16_channel`

## Requirements
- R1: On a cycle with `tick` high, `count` advances by one, wrapping from all-ones to zero. On a cycle with `tick` low, `count`, `pwm_out` and `match_flag` do not change.
- R2: A match happens on a tick where the comparator is enabled and the counter's next value equals the compare value. A match drives `pwm_out` high at that same clock edge.
- R3: A tick that wraps the counter drives `pwm_out` low unless a match occurs on the same tick. With ticks every cycle, `pwm_out` is high for 2^CNT_W − compare ticks of each period.
- R4: With a compare value of zero, the match and the wrap fall on the same tick and the set wins. `pwm_out` then stays high for the whole period.
- R5: Write address k loads `wr_data` into compare bits [k*BYTE_W +: BYTE_W]. A write to address 0 clears `cmp_en`. A write to address CNT_W/BYTE_W−1 sets `cmp_en`.
- R6: While `cmp_en` is low, no match occurs, `match_flag` is not set by the compare, and `pwm_out` goes low at the next wrap and stays low.
- R7: A match sets `match_flag`, which then holds until a cycle with `flag_clr` high clears it. If a match and `flag_clr` fall in the same cycle, the flag is set.
- R8: `irq` is registered. It is high in a cycle exactly when `match_flag` is high in that cycle and `irq_en` was high in the previous cycle.
- R9: A synchronous reset clears the counter, the compare value, `cmp_en`, `match_flag`, `irq` and `pwm_out`.
- R10: With an all-ones compare value, `pwm_out` is high for exactly one tick per period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timebase clock enable |
| wr_en | input | 1 | Compare byte write strobe |
| wr_addr | input | ADDR_W | Byte index of the compare value |
| wr_data | input | BYTE_W | Byte to write |
| irq_en | input | 1 | Match interrupt enable |
| flag_clr | input | 1 | Clears the match flag when high |
| count | output | CNT_W | Timebase counter value |
| cmp_en | output | 1 | Comparator enable bit |
| pwm_out | output | 1 | PWM output |
| match_flag | output | 1 | Sticky match flag |
| irq | output | 1 | Match interrupt |

## Verification
Every internal register of this block reaches a port within one clock, with one exception: the compare value is only visible through when `pwm_out` rises.

- A wrong counter state shows on `count` at the next tick.
- A lost or spurious enable shows as a missing or extra rising edge of `pwm_out` and a missing or extra `match_flag` set within one period.
- A corrupted compare byte shifts the rising edge, so a comparison against a behavioural model on every clock exposes it within one period.
- A wrong set/clear priority at a compare value of zero shows as a one-tick low glitch at the wrap.

// File: rtl/pwm16_pkg.sv
package pwm16_pkg;

  // Timebase events evaluated on an enabled tick
  typedef struct packed {
    logic match;
    logic wrap;
  } pwm_evt_t;

endpackage

// File: rtl/pwm16_timebase.sv
module pwm16_timebase #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cnt_nxt,
  output logic             wrap
);

  localparam logic [CNT_W-1:0] TOP = '1;

  assign cnt_nxt = cnt + CNT_W'(1);
  assign wrap    = tick && (cnt == TOP);

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (tick) cnt <= cnt_nxt;
  end

  // R1: advance by one per tick
  a_r1_advance: assert property (@(posedge clk) disable iff (rst)
    tick |=> (cnt == CNT_W'($past(cnt) + CNT_W'(1))));

  // R1: hold without a tick
  a_r1_hold: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(cnt));

endmodule

// File: rtl/pwm16_cmp_reg.sv
module pwm16_cmp_reg #(
  parameter int CNT_W  = 16,
  parameter int BYTE_W = 8,
  localparam int N_BYTES = CNT_W / BYTE_W,
  localparam int ADDR_W  = (N_BYTES > 1) ? $clog2(N_BYTES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [CNT_W-1:0]  cmp,
  output logic              cmp_en
);

  localparam logic [ADDR_W-1:0] TOP_IDX = ADDR_W'(N_BYTES - 1);
  localparam logic [ADDR_W-1:0] LOW_IDX = '0;

  for (genvar g = 0; g < N_BYTES; g++) begin : g_byte
    always_ff @(posedge clk) begin
      if (rst)
        cmp[g*BYTE_W +: BYTE_W] <= '0;
      else if (wr_en && (wr_addr == ADDR_W'(g)))
        cmp[g*BYTE_W +: BYTE_W] <= wr_data;
    end
  end

  // The top-byte write re-arms; it is checked first so that a one-byte build still arms.
  always_ff @(posedge clk) begin
    if (rst)                               cmp_en <= 1'b0;
    else if (wr_en && wr_addr == TOP_IDX)  cmp_en <= 1'b1;
    else if (wr_en && wr_addr == LOW_IDX)  cmp_en <= 1'b0;
  end

  // R5: a low-byte write disarms the comparator
  a_r5_low_disarms: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == LOW_IDX && N_BYTES > 1) |=> !cmp_en);

  // R5: a high-byte write arms the comparator
  a_r5_high_arms: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == TOP_IDX) |=> cmp_en);

endmodule

// File: rtl/pwm16_out_stage.sv
module pwm16_out_stage #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [CNT_W-1:0] cnt_nxt,
  input  logic             wrap,
  input  logic [CNT_W-1:0] cmp,
  input  logic             cmp_en,
  input  logic             irq_en,
  input  logic             flag_clr,
  output logic             pwm_out,
  output logic             match_flag,
  output logic             irq
);

  import pwm16_pkg::*;

  pwm_evt_t evt;
  logic     flag_d;

  assign evt.match = tick && cmp_en && (cnt_nxt == cmp);
  assign evt.wrap  = wrap;
  assign flag_d    = evt.match || (match_flag && !flag_clr);

  // Set has priority over clear
  always_ff @(posedge clk) begin
    if (rst)            pwm_out <= 1'b0;
    else if (evt.match) pwm_out <= 1'b1;
    else if (evt.wrap)  pwm_out <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      match_flag <= 1'b0;
      irq        <= 1'b0;
    end else begin
      match_flag <= flag_d;
      irq        <= flag_d && irq_en;
    end
  end

  // R2: a match drives the output high
  a_r2_match_sets: assert property (@(posedge clk) disable iff (rst)
    evt.match |=> pwm_out);

  // R3: a wrap without a match drives the output low
  a_r3_wrap_clears: assert property (@(posedge clk) disable iff (rst)
    (evt.wrap && !evt.match) |=> !pwm_out);

  // R6: the output never rises without a match
  a_r6_no_rise_without_match: assert property (@(posedge clk) disable iff (rst)
    (!pwm_out && !evt.match) |=> !pwm_out);

  // R7: the flag is sticky until cleared
  a_r7_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    (match_flag && !flag_clr) |=> match_flag);

  // R8: the interrupt needs the flag
  a_r8_irq_needs_flag: assert property (@(posedge clk) disable iff (rst)
    irq |-> match_flag);

endmodule

// File: rtl/pwm16_channel.sv
module pwm16_channel #(
  parameter int CNT_W  = 16,
  parameter int BYTE_W = 8,
  localparam int N_BYTES = CNT_W / BYTE_W,
  localparam int ADDR_W  = (N_BYTES > 1) ? $clog2(N_BYTES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              irq_en,
  input  logic              flag_clr,
  output logic [CNT_W-1:0]  count,
  output logic              cmp_en,
  output logic              pwm_out,
  output logic              match_flag,
  output logic              irq
);

  logic [CNT_W-1:0] cnt_nxt;
  logic [CNT_W-1:0] cmp;
  logic             wrap;

  pwm16_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk(clk), .rst(rst), .tick(tick),
    .cnt(count), .cnt_nxt(cnt_nxt), .wrap(wrap)
  );

  pwm16_cmp_reg #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_cmp (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cmp(cmp), .cmp_en(cmp_en)
  );

  pwm16_out_stage #(.CNT_W(CNT_W)) u_out (
    .clk(clk), .rst(rst), .tick(tick), .cnt_nxt(cnt_nxt), .wrap(wrap),
    .cmp(cmp), .cmp_en(cmp_en), .irq_en(irq_en), .flag_clr(flag_clr),
    .pwm_out(pwm_out), .match_flag(match_flag), .irq(irq)
  );

endmodule

// File: tb/sim_pwm16_channel.sv
module sim_pwm16_channel;

  localparam int CNT_W  = 8;
  localparam int BYTE_W = 4;
  localparam int NB     = CNT_W / BYTE_W;
  localparam int AW     = 1;
  localparam int PER    = 1 << CNT_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0, wr_en = 1'b0, irq_en = 1'b0, flag_clr = 1'b0;
  logic [AW-1:0]     wr_addr = '0;
  logic [BYTE_W-1:0] wr_data = '0;
  logic [CNT_W-1:0]  count;
  logic cmp_en, pwm_out, match_flag, irq;

  int n_cmp = 0, n_bad = 0;
  bit cmp_on = 0;

  always #2 clk = ~clk;

  pwm16_channel #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u0 (
    .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .irq_en(irq_en), .flag_clr(flag_clr), .count(count),
    .cmp_en(cmp_en), .pwm_out(pwm_out), .match_flag(match_flag), .irq(irq)
  );

  // Behavioural reference
  logic [CNT_W-1:0] m_cnt = '0, m_cmp = '0, m_nxt;
  bit m_en = 0, m_out = 0, m_flag = 0, m_irq = 0, m_hit, m_wrap;

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = '0; m_cmp = '0; m_en = 0; m_out = 0; m_flag = 0; m_irq = 0;
    end else begin
      m_nxt  = m_cnt + 1'b1;
      m_hit  = tick && m_en && (m_nxt == m_cmp);
      m_wrap = tick && (m_cnt == '1);
      if (m_hit) m_out = 1;
      else if (m_wrap) m_out = 0;
      m_flag = m_hit || (m_flag && !flag_clr);
      m_irq  = m_flag && irq_en;
      if (tick) m_cnt = m_nxt;
      if (wr_en) begin
        m_cmp[wr_addr*BYTE_W +: BYTE_W] = wr_data;
        if (wr_addr == AW'(NB-1)) m_en = 1;
        else if (wr_addr == '0) m_en = 0;
      end
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (cmp_on) begin
    chk("R1 count", 32'(count), 32'(m_cnt));
    chk("R5 cmp_en", 32'(cmp_en), 32'(m_en));
    chk("R2/R3 pwm_out", 32'(pwm_out), 32'(m_out));
    chk("R7 match_flag", 32'(match_flag), 32'(m_flag));
    chk("R8 irq", 32'(irq), 32'(m_irq));
  end

  task automatic wr(int a, int d);
    @(negedge clk); wr_en = 1; wr_addr = AW'(a); wr_data = BYTE_W'(d);
    @(negedge clk); wr_en = 0;
  endtask

  task automatic set_cmp(int v);
    wr(0, v & 'hF);
    wr(1, (v >> 4) & 'hF);
  endtask

  task automatic wait_zero();
    do @(negedge clk); while (count != '0);
  endtask

  // High ticks over one period starting at count zero; ticks every cycle
  task automatic duty(string req, int exp);
    int hi = 0;
    wait_zero();
    for (int i = 0; i < PER; i++) begin
      if (pwm_out) hi++;
      @(negedge clk);
    end
    chk(req, 32'(hi), 32'(exp));
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    cmp_on = 1;
    rst = 0;
    // R9: reset state
    chk("R9 reset count", 32'(count), 0);
    chk("R9 reset pwm", 32'(pwm_out), 0);
    chk("R9 reset en", 32'(cmp_en), 0);
    chk("R9 reset flag", 32'(match_flag | irq), 0);

    irq_en = 1;
    tick = 1;
    // R5: low byte write disarms, high byte write arms
    wr(0, 0);
    chk("R5 low byte disarms", 32'(cmp_en), 0);
    wr(1, 4);
    chk("R5 high byte arms", 32'(cmp_en), 1);

    duty("R3 duty 0x40", PER - 'h40);
    chk("R7 flag set after match", 32'(match_flag), 1);
    @(negedge clk); flag_clr = 1; @(negedge clk); flag_clr = 0;
    chk("R7 flag cleared", 32'(match_flag), 0);

    set_cmp(0);
    duty("R4 zero compare constant high", PER);
    duty("R4 zero compare second period", PER);

    set_cmp('hFF);
    duty("R10 all-ones single tick", 1);

    set_cmp('h30);
    wr(0, 'h0);
    chk("R6 disarmed", 32'(cmp_en), 0);
    @(negedge clk); flag_clr = 1; @(negedge clk); flag_clr = 0;
    duty("R6 disabled zero duty", 0);
    chk("R6 no flag while disarmed", 32'(match_flag), 0);

    // Gated ticks, random clears and interrupt enable toggling (R1, R7, R8)
    set_cmp('h10);
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      tick     = ($urandom_range(0, 3) != 0);
      flag_clr = ($urandom_range(0, 15) == 0);
      irq_en   = ($urandom_range(0, 7) != 0);
    end
    tick = 1;
    flag_clr = 0;
    repeat (4) @(negedge clk);

    summary();
    $finish;
  end

endmodule